// File: doc/BRIEF.md
# FIFO-Buffered SPI Master with Register Interface

This block is an SPI master that a processor controls through a small 32-bit register port. Software writes outgoing words into a transmit queue, selects the word length, the serial clock mode, the bit rate and one of several slave-select lines. It then raises an exchange bit. Until that bit is set, queued words stay in the queue. Once it is set, the master shifts every queued word out on MOSI, most significant bit first. For each word it sends, it puts one received word into a receive queue. The exchange bit drops by itself when the queue has drained and the last word has finished.

Two interrupt sources, transmit-queue-empty and receive-data-ready, are enabled separately and combined onto one request line. A soft-reset register empties both queues and stops the shifter without losing the configuration.

Register word addresses, given as byte offsets, are: 0x00 receive data, 0x04 transmit data, 0x08 control, 0x0C interrupt enable, 0x14 status, 0x1C soft reset.

Top module: `regspi_master`

## Requirements
- R1: After reset the control and interrupt-enable registers read 0, status reads 0x1 (bit 0 = transmit queue empty, bit 3 = receive data ready), `irq` is low, `spi_sclk` is low and every `spi_ss` line is high.
- R2: Control bits are: 0 enable, 1 master, 2 exchange, 4 clock polarity, 5 clock phase, 6 slave-select gap, 7 slave-select active level, [12:8] word length minus one, [16 +: RATE_W] rate code and [24 +: log2(NUM_CS)] slave index. Other control bits read 0, and the interrupt-enable register keeps only bits 0 and 3.
- R3: The transmit queue holds FIFO_DEPTH words. Each write to 0x04 queues one word, and a write to a full queue is dropped.
- R4: No serial clock edge occurs while the exchange bit is clear. When enable, master and exchange are all set, queued words are shifted. The exchange bit returns to 0 once the transmit queue is empty and the shifter is idle.
- R5: A word is sent MSB first with length = field + 1 (1 to 32). Only the low bits of the written word are sent, and the received word is right-justified with zeros above.
- R6: With rate code n, the serial clock period is 4 << n system clocks.
- R7: `spi_sclk` rests at the polarity bit. With phase 0, data is sampled on the edge leaving the rest level; with phase 1, it is sampled on the edge returning to it.
- R8: During an exchange only the indexed `spi_ss` line is driven to the active-level bit, and every other line is driven to its inverse.
- R9: With the gap bit clear, slave select stays asserted across consecutive words. With the gap bit set, it is released for one half bit period between words.
- R10: Status bit 3 is 1 whenever the receive queue is non-empty. Each read of 0x00 returns the oldest word and removes it. A word received while the queue is full is discarded.
- R11: `irq` = (enable bit 0 and transmit queue empty) or (enable bit 3 and receive queue non-empty).
- R12: Writing 1 in bit 0 of 0x1C empties both queues, returns the shifter to idle and clears the exchange bit. The other control bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (removes a word when the address is receive data) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Interrupt request |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss | output | NUM_CS | Slave selects |

## Verification
The bench uses the default parameters: an 8-deep queue, four slave selects and a 3-bit rate code. With these values a nine-word burst overruns the transmit queue, and two exchanges overrun the receive queue. The slowest ratio of 512 stays short enough to time a full bit period, and a non-zero slave index checks the select decode. MISO is looped back to MOSI, and a bench-side monitor samples MOSI on the edge that each clock mode names, so both the sent and the received words are checked against the queued values.

// File: rtl/regspi_pkg.sv
package regspi_pkg;
   // register word indices (byte offset >> 2)
   localparam logic [2:0] WA_RXD = 3'd0;
   localparam logic [2:0] WA_TXD = 3'd1;
   localparam logic [2:0] WA_CTL = 3'd2;
   localparam logic [2:0] WA_IEN = 3'd3;
   localparam logic [2:0] WA_STA = 3'd5;
   localparam logic [2:0] WA_RST = 3'd7;

   // control bit positions
   localparam int CB_EN   = 0;
   localparam int CB_MST  = 1;
   localparam int CB_XCH  = 2;
   localparam int CB_POL  = 4;
   localparam int CB_PHA  = 5;
   localparam int CB_GAP  = 6;
   localparam int CB_SSP  = 7;
   localparam int CB_LEN  = 8;
   localparam int CB_RATE = 16;
   localparam int CB_CS   = 24;

   localparam int IE_TXE = 0;
   localparam int IE_RXR = 3;

   typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_GAP} sh_state_t;

   typedef struct packed {
      logic       cpol;
      logic       cpha;
      logic       ss_gap;
      logic [4:0] len_m1;
   } shift_cfg_t;
endpackage

// File: rtl/regspi_fifo.sv
module regspi_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("regspi_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop)  rp <= rp + AW'(1);
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + (AW+1)'(1);
            2'b01:   cnt <= cnt - (AW+1)'(1);
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/regspi_baud.sv
module regspi_baud #(
   parameter int RATE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);
   localparam int CNT_W = (1 << RATE_W) + 1;

   if (RATE_W < 1 || RATE_W > 5) begin : g_bad_rate
      $error("regspi_baud: RATE_W out of range");
   end

   logic [CNT_W-1:0] cnt, half_m1;

   assign half_m1 = (CNT_W'(2) << rate) - CNT_W'(1);
   assign tick    = run && (cnt == half_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || tick)   cnt <= '0;
      else                     cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/regspi_shifter.sv
module regspi_shifter
   import regspi_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        flush,
   input  logic        go,
   input  shift_cfg_t  cfg,
   input  logic        tick,
   input  logic        tx_avail,
   input  logic [31:0] tx_word,
   output logic        tx_pop,
   output logic        rx_push,
   output logic [31:0] rx_word,
   output logic        busy,
   output logic        ss_active,
   output logic        sclk,
   output logic        mosi,
   input  logic        miso
);
   sh_state_t   state;
   logic [5:0]  edge_no;
   logic        sclk_ph, mosi_q, load, edge_last, leading, sample;
   logic [31:0] txs, rxs, rx_now, aligned;

   assign edge_last = (edge_no == {cfg.len_m1, 1'b1});
   assign leading   = !edge_no[0];
   assign sample    = (leading != cfg.cpha);
   assign rx_now    = {rxs[30:0], miso};
   assign aligned   = tx_word << (5'd31 - cfg.len_m1);

   always_comb begin
      load = 1'b0;
      unique case (state)
         SH_IDLE:  load = go && tx_avail;
         SH_SHIFT: load = tick && edge_last && go && tx_avail && !cfg.ss_gap;
         SH_GAP:   load = tick && go && tx_avail;
         default:  load = 1'b0;
      endcase
   end

   assign tx_pop    = load && !flush;
   assign rx_push   = (state == SH_SHIFT) && tick && edge_last && !flush;
   assign rx_word   = sample ? rx_now : rxs;
   assign busy      = (state != SH_IDLE);
   assign ss_active = (state == SH_SHIFT);
   assign sclk      = cfg.cpol ^ sclk_ph;
   assign mosi      = mosi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SH_IDLE;
         edge_no <= '0;
         sclk_ph <= 1'b0;
         mosi_q  <= 1'b0;
         txs     <= '0;
         rxs     <= '0;
      end else if (flush) begin
         state   <= SH_IDLE;
         edge_no <= '0;
         sclk_ph <= 1'b0;
      end else begin
         case (state)
            SH_SHIFT: if (tick) begin
               sclk_ph <= ~sclk_ph;
               if (sample) rxs <= rx_now;
               else begin
                  mosi_q <= txs[31];
                  txs    <= txs << 1;
               end
               if (edge_last) begin
                  edge_no <= '0;
                  if (!(go && tx_avail)) state <= SH_IDLE;
                  else if (cfg.ss_gap)   state <= SH_GAP;
               end else begin
                  edge_no <= edge_no + 6'd1;
               end
            end
            SH_GAP: if (tick && !(go && tx_avail)) state <= SH_IDLE;
            default: ;
         endcase
         if (load) begin
            state   <= SH_SHIFT;
            edge_no <= '0;
            sclk_ph <= 1'b0;
            rxs     <= '0;
            if (!cfg.cpha) begin
               mosi_q <= aligned[31];
               txs    <= aligned << 1;
            end else begin
               txs    <= aligned;
            end
         end
      end
   end
endmodule

// File: rtl/regspi_master.sv
module regspi_master
   import regspi_pkg::*;
#(
   parameter int FIFO_DEPTH = 8,
   parameter int NUM_CS     = 4,
   parameter int RATE_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [NUM_CS-1:0] spi_ss
);
   localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
   localparam logic [31:0] CTL_MASK = 32'h0000_1FF7
                                    | (((32'd1 << RATE_W) - 32'd1) << CB_RATE)
                                    | (((32'd1 << CS_W) - 32'd1) << CB_CS);
   localparam logic [31:0] IEN_MASK = (32'd1 << IE_TXE) | (32'd1 << IE_RXR);

   if (NUM_CS < 1 || CS_W > 8) begin : g_bad_cs
      $error("regspi_master: NUM_CS out of range");
   end

   logic [31:0] ctl_q, ien_q, tx_dout, rx_dout, rx_word;
   logic [2:0]  wa;
   logic        wr_ctl, wr_txd, soft_rst, rd_rxd;
   logic        tx_empty, tx_full, rx_empty, rx_full;
   logic        tx_pop, rx_push, busy, ss_active, tick, go;
   logic        sspol, cpol, xch;
   logic [CS_W-1:0]   cs_idx;
   logic [RATE_W-1:0] rate;
   shift_cfg_t  cfg;
   logic        unused_bits;

   assign wa       = bus_addr[4:2];
   assign wr_ctl   = bus_wr && (wa == WA_CTL);
   assign wr_txd   = bus_wr && (wa == WA_TXD);
   assign soft_rst = bus_wr && (wa == WA_RST) && bus_wdata[0];
   assign rd_rxd   = bus_rd && (wa == WA_RXD);
   assign unused_bits = ^{bus_addr[1:0], tx_full, rx_full};

   assign sspol  = ctl_q[CB_SSP];
   assign cpol   = ctl_q[CB_POL];
   assign xch    = ctl_q[CB_XCH];
   assign cs_idx = ctl_q[CB_CS +: CS_W];
   assign rate   = ctl_q[CB_RATE +: RATE_W];
   assign go     = ctl_q[CB_EN] && ctl_q[CB_MST] && xch;
   assign cfg    = '{cpol:   ctl_q[CB_POL],
                     cpha:   ctl_q[CB_PHA],
                     ss_gap: ctl_q[CB_GAP],
                     len_m1: ctl_q[CB_LEN +: 5]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         ien_q <= '0;
      end else begin
         if (soft_rst)                          ctl_q[CB_XCH] <= 1'b0;
         else if (wr_ctl)                       ctl_q <= bus_wdata & CTL_MASK;
         else if (xch && !busy && tx_empty)     ctl_q[CB_XCH] <= 1'b0;
         if (bus_wr && (wa == WA_IEN))          ien_q <= bus_wdata & IEN_MASK;
      end
   end

   regspi_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) i_txq (
      .clk(clk), .rst_n(rst_n), .flush(soft_rst),
      .push(wr_txd), .din(bus_wdata), .pop(tx_pop), .dout(tx_dout),
      .empty(tx_empty), .full(tx_full));

   regspi_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) i_rxq (
      .clk(clk), .rst_n(rst_n), .flush(soft_rst),
      .push(rx_push), .din(rx_word), .pop(rd_rxd), .dout(rx_dout),
      .empty(rx_empty), .full(rx_full));

   regspi_baud #(.RATE_W(RATE_W)) i_baud (
      .clk(clk), .rst_n(rst_n), .run(busy), .rate(rate), .tick(tick));

   regspi_shifter i_shift (
      .clk(clk), .rst_n(rst_n), .flush(soft_rst), .go(go), .cfg(cfg),
      .tick(tick), .tx_avail(!tx_empty), .tx_word(tx_dout), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_word(rx_word), .busy(busy), .ss_active(ss_active),
      .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso));

   for (genvar i = 0; i < NUM_CS; i++) begin : g_ss
      assign spi_ss[i] = (ss_active && (cs_idx == CS_W'(i))) ? sspol : ~sspol;
   end

   assign irq = (ien_q[IE_TXE] && tx_empty) || (ien_q[IE_RXR] && !rx_empty);

   always_comb begin
      unique case (wa)
         WA_RXD:  bus_rdata = rx_empty ? 32'd0 : rx_dout;
         WA_CTL:  bus_rdata = ctl_q;
         WA_IEN:  bus_rdata = ien_q;
         WA_STA:  bus_rdata = {28'd0, !rx_empty, 2'b00, tx_empty};
         default: bus_rdata = 32'd0;
      endcase
   end
endmodule

// File: rtl/regspi_chk.sv
module regspi_chk #(
   parameter int NUM_CS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CS-1:0] spi_ss,
   input logic              spi_sclk,
   input logic              sspol,
   input logic              cpol,
   input logic              ss_active,
   input logic              soft_rst,
   input logic              wr_ctl,
   input logic              tx_empty,
   input logic              rx_empty,
   input logic              busy,
   input logic              xch
);
   // R8
   ss_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(spi_ss ^ {NUM_CS{~sspol}}));

   // R7
   sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_active |-> (spi_sclk == cpol));

   // R12
   soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (tx_empty && rx_empty && !busy && !xch));

   // R4
   xch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xch && !busy && tx_empty && !wr_ctl) |=> !xch);

   // R4
   idle_no_xch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!xch && !busy) |=> !busy);
endmodule

bind regspi_master regspi_chk #(.NUM_CS(NUM_CS)) i_chk (
   .clk(clk), .rst_n(rst_n), .spi_ss(spi_ss), .spi_sclk(spi_sclk),
   .sspol(sspol), .cpol(cpol), .ss_active(ss_active), .soft_rst(soft_rst),
   .wr_ctl(wr_ctl), .tx_empty(tx_empty), .rx_empty(rx_empty), .busy(busy),
   .xch(xch));

// File: tb/test_regspi_master.sv
`timescale 1ns/1ps
module test_regspi_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        irq, spi_sclk, spi_mosi, spi_miso;
   logic [3:0]  spi_ss;

   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;
   assign spi_miso = spi_mosi;

   regspi_master i_regspi_master (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .spi_ss(spi_ss));

   // MOSI monitor: samples on the edge the mode names
   logic        mon_on = 0, mon_cpol = 0, mon_cpha = 0;
   int          mon_len = 8, mon_bits = 0, mon_n = 0, mon_edges = 0, ss_rise = 0;
   logic [31:0] mon_word = 0;
   logic [31:0] mon_q [16];

   always @(spi_sclk) if (mon_on) begin
      mon_edges++;
      if ((spi_sclk != mon_cpol) == !mon_cpha) begin
         mon_word = {mon_word[30:0], spi_mosi};
         mon_bits++;
         if (mon_bits == mon_len) begin
            if (mon_n < 16) mon_q[mon_n] = mon_word;
            mon_n++;
            mon_bits = 0;
            mon_word = 0;
         end
      end
   end
   always @(posedge spi_ss[0]) if (mon_on) ss_rise++;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1 bus_wr = 1'b0;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk); #1 bus_rd = 1'b0;
   endtask

   function automatic logic [31:0] mk(bit pha, bit pol, bit gap, bit ssp,
                                      int len, int rate, int cs, bit x);
      return 32'h3 | (32'(x) << 2) | (32'(pol) << 4) | (32'(pha) << 5)
           | (32'(gap) << 6) | (32'(ssp) << 7) | (32'(len - 1) << 8)
           | (32'(rate) << 16) | (32'(cs) << 24);
   endfunction

   task automatic mon_start(int len, bit pol, bit pha);
      mon_len = len; mon_cpol = pol; mon_cpha = pha;
      mon_bits = 0; mon_n = 0; mon_edges = 0; mon_word = 0; ss_rise = 0;
      mon_on = 1;
   endtask

   task automatic wait_done();
      logic [31:0] d;
      for (int i = 0; i < 20000; i++) begin
         rd(5'h08, d);
         if (!d[2]) break;
      end
      repeat (2) @(negedge clk);
      mon_on = 0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 ss", {28'd0, spi_ss}, 32'hF);
      chk("R1 sclk", {31'd0, spi_sclk}, 0);
      chk("R1 irq", {31'd0, irq}, 0);
      rd(5'h08, d); chk("R1 ctl", d, 0);
      rd(5'h0C, d); chk("R1 ien", d, 0);
      rd(5'h14, d); chk("R1 status", d, 32'h1);
   endtask

   task automatic t_regs();
      logic [31:0] d, v;
      v = mk(1, 0, 1, 0, 12, 5, 3, 0);
      wr(5'h08, v);
      rd(5'h08, d); chk("R2 ctl readback", d, v);
      wr(5'h08, 32'hFFFF_FFFF);
      repeat (2) @(negedge clk);
      rd(5'h08, d); chk("R2 R4 ctl mask, empty xch drops", d, 32'h0307_1FF3);
      wr(5'h0C, 32'hFFFF_FFFF);
      rd(5'h0C, d); chk("R2 ien mask", d, 32'h9);
      wr(5'h0C, 0);
      wr(5'h08, 0);
   endtask

   task automatic t_basic();
      logic [31:0] d;
      wr(5'h08, mk(0, 0, 0, 0, 8, 0, 0, 0));
      mon_start(8, 0, 0);
      wr(5'h04, 32'hA5); wr(5'h04, 32'h3C);
      repeat (40) @(negedge clk);
      chk("R4 no edges before exchange", mon_edges, 0);
      rd(5'h14, d); chk("R4 rx empty before exchange", d, 32'h0);
      wr(5'h08, mk(0, 0, 0, 0, 8, 0, 0, 1));
      wait_done();
      rd(5'h08, d); chk("R4 exchange bit dropped", {31'd0, d[2]}, 0);
      chk("R5 words on mosi", mon_n, 2);
      chk("R5 mosi word0", mon_q[0], 32'hA5);
      chk("R5 mosi word1", mon_q[1], 32'h3C);
      rd(5'h00, d); chk("R10 rx word0", d, 32'hA5);
      rd(5'h00, d); chk("R10 rx word1", d, 32'h3C);
   endtask

   task automatic one_word(int len, logic [31:0] w, logic [31:0] exp, string tag);
      logic [31:0] d;
      wr(5'h08, mk(0, 0, 0, 0, len, 0, 0, 0));
      mon_start(len, 0, 0);
      wr(5'h04, w);
      wr(5'h08, mk(0, 0, 0, 0, len, 0, 0, 1));
      wait_done();
      chk({tag, " mosi"}, mon_q[0], exp);
      rd(5'h00, d); chk({tag, " rx"}, d, exp);
   endtask

   task automatic t_lengths();
      one_word(1, 32'h1, 32'h1, "R5 len1");
      one_word(32, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R5 len32");
      one_word(13, 32'h1ABC, 32'h1ABC, "R5 len13");
      one_word(4, 32'hFFF5, 32'h5, "R5 len4 upper bits ignored");
   endtask

   task automatic t_rate(int r);
      time t0, t1;
      wr(5'h08, mk(0, 0, 0, 0, 8, r, 0, 0));
      wr(5'h04, 32'h55);
      mon_start(8, 0, 0);
      wr(5'h08, mk(0, 0, 0, 0, 8, r, 0, 1));
      @(posedge spi_sclk); t0 = $time;
      @(posedge spi_sclk); t1 = $time;
      chk("R6 sclk period", 32'((t1 - t0) / 8), 32'(4 << r));
      wait_done();
      begin logic [31:0] d; rd(5'h00, d); end
   endtask

   task automatic t_modes();
      logic [31:0] d;
      for (int m = 0; m < 4; m++) begin
         bit pol = m[1], pha = m[0];
         wr(5'h08, mk(pha, pol, 0, 0, 8, 1, 0, 0));
         repeat (2) @(negedge clk);
         mon_start(8, pol, pha);
         wr(5'h04, 32'h96); wr(5'h04, 32'h4B);
         wr(5'h08, mk(pha, pol, 0, 0, 8, 1, 0, 1));
         wait_done();
         chk("R7 mosi word0 on mode edge", mon_q[0], 32'h96);
         chk("R7 mosi word1 on mode edge", mon_q[1], 32'h4B);
         rd(5'h00, d); chk("R7 rx word0", d, 32'h96);
         rd(5'h00, d); chk("R7 rx word1", d, 32'h4B);
         chk("R7 sclk rest level", {31'd0, spi_sclk}, {31'd0, pol});
      end
      wr(5'h08, 0);
   endtask

   task automatic t_select(bit ssp, int cs, logic [3:0] exp_on);
      logic [31:0] d;
      wr(5'h08, mk(0, 0, 0, ssp, 8, 0, cs, 0));
      wr(5'h04, 32'h81);
      mon_start(8, 0, 0);
      wr(5'h08, mk(0, 0, 0, ssp, 8, 0, cs, 1));
      repeat (6) @(negedge clk);
      chk("R8 select during exchange", {28'd0, spi_ss}, {28'd0, exp_on});
      wait_done();
      chk("R8 select after exchange", {28'd0, spi_ss}, ssp ? 32'h0 : 32'hF);
      rd(5'h00, d);
   endtask

   task automatic t_gap(bit gap, int exp_rises);
      logic [31:0] d;
      wr(5'h08, mk(0, 0, gap, 0, 8, 0, 0, 0));
      wr(5'h04, 32'h12); wr(5'h04, 32'h34);
      mon_start(8, 0, 0);
      wr(5'h08, mk(0, 0, gap, 0, 8, 0, 0, 1));
      wait_done();
      chk("R9 select releases", ss_rise, exp_rises);
      rd(5'h00, d); chk("R9 rx word0", d, 32'h12);
      rd(5'h00, d); chk("R9 rx word1", d, 32'h34);
   endtask

   task automatic t_txfull();
      logic [31:0] d;
      wr(5'h08, mk(0, 0, 0, 0, 8, 0, 0, 0));
      for (int i = 0; i < 9; i++) wr(5'h04, 32'h11 + 32'(i));
      mon_start(8, 0, 0);
      wr(5'h08, mk(0, 0, 0, 0, 8, 0, 0, 1));
      wait_done();
      chk("R3 words sent from full queue", mon_n, 8);
      for (int i = 0; i < 8; i++) begin
         rd(5'h00, d); chk("R3 queued word", d, 32'h11 + 32'(i));
      end
      rd(5'h14, d); chk("R3 ninth write dropped", d, 32'h1);
   endtask

   task automatic t_rxfull();
      logic [31:0] d;
      wr(5'h08, mk(0, 0, 0, 0, 8, 0, 0, 0));
      for (int i = 1; i <= 8; i++) wr(5'h04, 32'(i));
      wr(5'h08, mk(0, 0, 0, 0, 8, 0, 0, 1));
      wait_done();
      wr(5'h04, 32'h09); wr(5'h04, 32'h0A);
      wr(5'h08, mk(0, 0, 0, 0, 8, 0, 0, 1));
      wait_done();
      rd(5'h14, d); chk("R10 status rx ready", d, 32'h9);
      for (int i = 1; i <= 8; i++) begin
         rd(5'h00, d); chk("R10 full rx keeps oldest", d, 32'(i));
      end
      rd(5'h14, d); chk("R10 status after drain", d, 32'h1);
      rd(5'h00, d); chk("R10 empty read", d, 0);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      wr(5'h08, mk(0, 0, 0, 0, 8, 0, 0, 0));
      wr(5'h0C, 32'h1);
      @(negedge clk); chk("R11 irq tx empty", {31'd0, irq}, 1);
      wr(5'h04, 32'h77);
      @(negedge clk); chk("R11 irq tx not empty", {31'd0, irq}, 0);
      wr(5'h0C, 32'h8);
      @(negedge clk); chk("R11 irq rx empty", {31'd0, irq}, 0);
      wr(5'h08, mk(0, 0, 0, 0, 8, 0, 0, 1));
      wait_done();
      chk("R11 irq rx ready", {31'd0, irq}, 1);
      rd(5'h00, d);
      @(negedge clk); chk("R11 irq after read", {31'd0, irq}, 0);
      wr(5'h0C, 0);
   endtask

   task automatic t_softrst();
      logic [31:0] d, v;
      v = mk(0, 0, 0, 0, 8, 0, 2, 0);
      wr(5'h08, v);
      for (int i = 0; i < 3; i++) wr(5'h04, 32'hC0 + 32'(i));
      wr(5'h1C, 32'h1);
      rd(5'h14, d); chk("R12 queues emptied", d, 32'h1);
      rd(5'h08, d); chk("R12 control kept", d, v);
      for (int i = 0; i < 8; i++) wr(5'h04, 32'hD0 + 32'(i));
      wr(5'h08, v | 32'h4);
      repeat (20) @(negedge clk);
      wr(5'h1C, 32'h1);
      repeat (2) @(negedge clk);
      chk("R12 select released", {28'd0, spi_ss}, 32'hF);
      rd(5'h08, d); chk("R12 exchange cleared, rest kept", d, v);
      rd(5'h14, d); chk("R12 status after mid reset", d, 32'h1);
      repeat (40) @(negedge clk);
      rd(5'h14, d); chk("R12 nothing received after reset", d, 32'h1);
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_basic();
      t_lengths();
      t_rate(3);
      t_rate(7);
      t_modes();
      t_select(1, 2, 4'b0100);
      t_select(0, 3, 4'b0111);
      t_gap(0, 1);
      t_gap(1, 2);
      t_txfull();
      t_rxfull();
      t_irq();
      t_softrst();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule